// File: doc/BRIEF.md
# Mode-Dependent Seven-Pin Port Multiplexer

This block owns seven general-purpose pins. For each pin it decides whether the pin is ordinary port I/O, a bus-arbitration pin, a bus-request-out pin or a chip-select pin. A write-only direction register and a read/write data register hold the port state. A small register bus reaches both registers and also reads back the pin state.

The pin function depends on four things: a 3-bit operating mode, an expansion enable, an arbitration enable with a bus-request-out enable, and five chip-select enables. The routing is purely combinational from the registers and these inputs. A change to any of them shows on the pins in the same cycle.

The mode input counts as expanded when it is 1, 2 or 4, or when it is 7 with the expansion enable high. Any value other than 1, 2, 4 and 7 is handled as mode 7 with expansion off.

Top module: `gpio_pinmux7`

## Requirements
- R1: After reset, the data register is 0 and direction bits 6..1 are 0. Direction bit 0 resets to 1 when `mode` is 1 or 2 during reset, and to 0 for every other `mode` value.
- R2: A write to address 0 loads `reg_wdata[6:0]` into the direction register. A read of address 0, or of address 3, returns 0x00.
- R3: A write to address 1 loads `reg_wdata[6:0]` into the data register. A read of address 1 returns `{1'b0, data}`.
- R4: When not expanded, every pin is plain I/O whatever the other enables are: `pin_oe[n]` = direction bit n, `pin_out[n]` = data bit n, and `bus_req_in` = 0.
- R5: When expanded with `arb_en` = 1, pin 6 is an input (oe 0, out 0) and `bus_req_in` = `pin_in[6]`. Pin 5 is an output (oe 1) driving `bus_ack`.
- R6: When expanded with `breq_out_en` = 1, pin 4 is an output (oe 1) driving `breq_out`. This takes priority over chip-select 4.
- R7: When expanded with `cs_en[n]` = 1 (n = 0..4, pin not claimed by R6), `pin_out[n]` = `cs_sig[n]` and `pin_oe[n]` = direction bit n.
- R8: Any pin that no active function claims is plain I/O, as in R4.
- R9: A read of address 2 returns the pin state with bit 7 = 0. Bit n is the data bit for a plain pin whose direction bit is 1, and `pin_in[n]` for every other pin.
- R10: `mode` values 0, 3, 5 and 6 behave exactly as mode 7 with `exp_en` = 0. This covers both the routing and the reset value of direction bit 0.
- R11: `reg_rdata` is 0 whenever `reg_rd` is 0. Routing changes caused by the mode and enable inputs take effect in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode |
| exp_en | input | 1 | Expansion enable, used in mode 7 |
| arb_en | input | 1 | Enables the bus arbitration pins 6 and 5 |
| breq_out_en | input | 1 | Enables the bus-request-out function on pin 4 |
| cs_en | input | 5 | Per-pin chip-select enables for pins 4..0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 direction, 1 data, 2 pin state |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| bus_ack | input | 1 | Internal bus-acknowledge value for pin 5 |
| breq_out | input | 1 | Internal bus-request-out value for pin 4 |
| cs_sig | input | 5 | Internal chip-select values for pins 4..0 |
| bus_req_in | output | 1 | Bus request sampled from pin 6 |
| pin_in | input | 7 | Sampled pad inputs |
| pin_out | output | 7 | Pad output values |
| pin_oe | output | 7 | Pad output enables |

## Verification
The bench sweeps reset across all eight mode values. A design that keyed the bit-0 reset value on the wrong modes, or forgot the illegal-mode fallback, would show the wrong output enable on pin 0 right after reset. Random cycles then combine arbitration, bus-request-out and chip-select enables under expanded and flat modes. This exposes a design that lets chip-select 4 win over bus-request-out, that routes function pins while not expanded, or that drives a chip-select pin whose direction bit is 0. Reads of every address check that the direction register never reads back and that the pin-state view mixes data and pad values per pin as specified.

// File: rtl/gpio_pinmux7.sv
module gpio_pinmux7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       exp_en,
  input  logic       arb_en,
  input  logic       breq_out_en,
  input  logic [4:0] cs_en,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bus_ack,
  input  logic       breq_out,
  input  logic [4:0] cs_sig,
  output logic       bus_req_in,
  input  logic [6:0] pin_in,
  output logic [6:0] pin_out,
  output logic [6:0] pin_oe
);
  localparam logic [1:0] A_DIR = 2'd0, A_DAT = 2'd1, A_PIN = 2'd2;

  logic [6:0] dir_q, dat_q;

  wire mode_lo  = (mode == 3'd1) || (mode == 3'd2);
  wire expanded = mode_lo || (mode == 3'd4) || ((mode == 3'd7) && exp_en);
  wire arb      = expanded && arb_en;
  wire bro      = expanded && breq_out_en;
  wire [4:0] cs_act = {cs_en[4] & ~breq_out_en, cs_en[3:0]} & {5{expanded}};
  wire [6:0] func   = {arb, arb, bro | cs_act[4], cs_act[3:0]};
  wire [6:0] plain_out = dir_q & ~func;
  wire [6:0] pin_state = (plain_out & dat_q) | (~plain_out & pin_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= {6'b0, mode_lo};
      dat_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_DIR) dir_q <= reg_wdata[6:0];
      if (reg_addr == A_DAT) dat_q <= reg_wdata[6:0];
    end
  end

  always_comb begin
    pin_oe  = dir_q;
    pin_out = dat_q;
    for (int n = 0; n < 5; n++)
      if (cs_act[n]) pin_out[n] = cs_sig[n];
    if (bro) begin
      pin_oe[4]  = 1'b1;
      pin_out[4] = breq_out;
    end
    if (arb) begin
      pin_oe[6]  = 1'b0;
      pin_out[6] = 1'b0;
      pin_oe[5]  = 1'b1;
      pin_out[5] = bus_ack;
    end
  end

  assign bus_req_in = arb & pin_in[6];

  always_comb begin
    reg_rdata = '0;
    if (reg_rd)
      case (reg_addr)
        A_DAT:   reg_rdata = {1'b0, dat_q};
        A_PIN:   reg_rdata = {1'b0, pin_state};
        default: reg_rdata = '0;
      endcase
  end
endmodule

// File: rtl/gpio_pinmux7_chk.sv
module gpio_pinmux7_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       exp_en,
  input logic       arb_en,
  input logic       breq_out_en,
  input logic [4:0] cs_en,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       bus_ack,
  input logic       breq_out,
  input logic [4:0] cs_sig,
  input logic       bus_req_in,
  input logic [6:0] pin_out,
  input logic [6:0] pin_oe,
  input logic [6:0] dir_q,
  input logic [6:0] dat_q
);
  wire exp_c = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4) ||
               ((mode == 3'd7) && exp_en);

  AST_DIR_NO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |-> reg_rdata == 8'h00);  // R2
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> dir_q == $past(reg_wdata[6:0]));  // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> dat_q == $past(reg_wdata[6:0]));  // R3
  AST_FLAT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !exp_c |-> (pin_oe == dir_q && pin_out == dat_q && !bus_req_in));  // R4
  AST_ARB_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_c && arb_en) |-> (!pin_oe[6] && pin_oe[5] && pin_out[5] == bus_ack));  // R5
  AST_BREQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_c && breq_out_en) |-> (pin_oe[4] && pin_out[4] == breq_out));  // R6
  AST_CS0_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_c && cs_en[0]) |-> (pin_oe[0] == dir_q[0] && pin_out[0] == cs_sig[0]));  // R7
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 8'h00);  // R11
endmodule

bind gpio_pinmux7 gpio_pinmux7_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .exp_en(exp_en), .arb_en(arb_en),
  .breq_out_en(breq_out_en), .cs_en(cs_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_ack(bus_ack), .breq_out(breq_out), .cs_sig(cs_sig),
  .bus_req_in(bus_req_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .dir_q(dir_q), .dat_q(dat_q)
);

// File: tb/gpio_pinmux7_bench.sv
module gpio_pinmux7_bench;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 3'd7;
  logic exp_en = 0, arb_en = 0, breq_out_en = 0;
  logic [4:0] cs_en = 0, cs_sig = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_ack = 0, breq_out = 0, bus_req_in;
  logic [6:0] pin_in = 0, pin_out, pin_oe;
  logic [6:0] m_dir = 0, m_dat = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pinmux7 u_gpio_pinmux7 (.*);

  function automatic bit f_exp();
    return mode == 1 || mode == 2 || mode == 4 || (mode == 7 && exp_en);
  endfunction

  function automatic logic [6:0] f_func();
    bit e = f_exp();
    logic [6:0] f = 0;
    if (e && arb_en) f[6:5] = 2'b11;
    if (e && breq_out_en) f[4] = 1;
    for (int n = 0; n < 5; n++) if (e && cs_en[n]) f[n] = 1;
    return f;
  endfunction

  function automatic logic [6:0] f_oe();
    logic [6:0] o = m_dir;
    if (f_exp() && breq_out_en) o[4] = 1;
    if (f_exp() && arb_en) begin o[6] = 0; o[5] = 1; end
    return o;
  endfunction

  function automatic logic [6:0] f_out();
    logic [6:0] o = m_dat;
    bit e = f_exp();
    for (int n = 0; n < 5; n++) if (e && cs_en[n]) o[n] = cs_sig[n];
    if (e && breq_out_en) o[4] = breq_out;
    if (e && arb_en) begin o[6] = 0; o[5] = bus_ack; end
    return o;
  endfunction

  function automatic logic [7:0] f_rd(input logic [1:0] a);
    logic [6:0] po = m_dir & ~f_func();
    case (a)
      2'd1: return {1'b0, m_dat};
      2'd2: return {1'b0, (po & m_dat) | (~po & pin_in)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    check(req, {1'b0, pin_oe}, {1'b0, f_oe()});
    check(req, {1'b0, pin_out}, {1'b0, f_out()});
    check(req, {7'b0, bus_req_in}, {7'b0, f_exp() && arb_en && pin_in[6]});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) m_dir = d[6:0];
    if (a == 1) m_dat = d[6:0];
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 4; a++) begin
      reg_rd = 1; reg_addr = a[1:0];
      #0.5;
      check(req, reg_rdata, f_rd(a[1:0]));
    end
    reg_rd = 0;
    #0.5;
    check("R11", reg_rdata, 8'h00);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 / R10: reset value per mode, observed in flat mode 7
    for (int m = 0; m < 8; m++) begin
      rst_n = 0; mode = m[2:0]; exp_en = 0;
      #3;
      @(negedge clk); rst_n = 1;
      mode = 3'd7; exp_en = 0; #1;
      m_dat = 0; m_dir = {6'b0, (m == 1 || m == 2)};
      check(m == 1 || m == 2 ? "R1" : "R10", {1'b0, pin_oe}, {1'b0, m_dir});
      check("R1", {1'b0, pin_out}, 8'h00);
    end
    // R6 priority over chip-select 4
    mode = 3'd4; breq_out_en = 1; cs_en = 5'h1f; cs_sig = 5'h00; breq_out = 1;
    wr(0, 8'h00);
    #1; check_pins("R6");
    // R7 chip-select with direction 0 is input
    breq_out_en = 0; cs_sig = 5'h1f; #1; check_pins("R7");
    wr(0, 8'hff); #1; check_pins("R7");
    // R4 flat mode ignores enables
    mode = 3'd7; exp_en = 0; arb_en = 1; breq_out_en = 1; #1; check_pins("R4");
    // R11 same-cycle change
    exp_en = 1; #1; check_pins("R11");
    rd_all("R9");
    process::self().srandom(32'd2024);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      mode = $urandom_range(0, 7); exp_en = $urandom; arb_en = $urandom;
      breq_out_en = $urandom; cs_en = $urandom; cs_sig = $urandom;
      bus_ack = $urandom; breq_out = $urandom; pin_in = $urandom;
      if ($urandom_range(0, 2) == 0) wr($urandom_range(0, 1), $urandom);
      #1;
      check_pins(f_exp() ? (arb_en ? "R5" : "R8") : (mode inside {0,3,5,6} ? "R10" : "R4"));
      rd_all(i[0] ? "R3" : "R2");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule